// File: doc/BRIEF.md
# Segment-Page Map Address Translator

This block turns a 32-bit virtual address into a physical address with two on-chip lookup memories. A segment map, indexed by the current context and the virtual segment number, yields a page-group number. A page map, indexed by that group and the virtual page number, yields a 32-bit page entry. The entry holds a frame number, a valid flag, write and supervisor permissions, a non-cacheable flag and the used and modified status bits.

A CPU-side requester presents an address with write and user-mode flags. Each accepted request is answered by a one-cycle response pulse carrying the physical address, the non-cacheable flag and a two-bit fault code. A successful access writes the entry back with its status bits updated, so software sees which pages were touched and dirtied. A small maintenance port lets software write or read either map while no translation is running.

The default geometry is trimmed to keep the memories small. The segment field taken from the address is `SEG_BITS` wide, starting at bit 18, and the group number is `GRP_W` bits. Setting `SEG_BITS` to 12 and `GRP_W` to 7 gives the full layout: a 15-bit segment index built from address bits 29:18.

Top module: `spm_xlate`

## Requirements
- R1: Under synchronous active-high reset the block has no response pending (`rsp_valid`=0) and no maintenance read data (`mnt_rvalid`=0). After reset, with `mnt_valid` low, `busy`=0 and `mnt_ready`=1.
- R2: If virtual address bits 31:29 are neither 000 nor 111, the response carries fault code 1 (hole). The page map entry is not modified, even for a write.
- R3: The segment map index is {context[2:0], va[18+SEG_BITS-1:18]}, and the map returns a GRP_W-bit group. The page map index is {group, va[17:12]}, so different contexts address different segment entries.
- R4: A fault-free response gives `rsp_pa` = {entry[15:0], va[11:0]} (28 bits) and `rsp_nc` = entry bit 28.
- R5: An entry whose bit 31 (valid) is 0 gives fault code 2 (invalid).
- R6: Fault code 3 (protection) is given for a write when entry bit 30 (write allowed) is 0. It is also given for a user-mode access when entry bit 29 (supervisor only) is 1.
- R7: Only one fault code is reported per request. The hole fault wins over the invalid fault, and the invalid fault wins over the protection fault. Fault code 0 means success.
- R8: On success the entry is written back with bit 25 (used) set, and bit 24 (modified) is also set for a write. A faulting request leaves the entry unchanged.
- R9: A request is accepted at a rising edge where `req_valid`=1 and `busy`=0. `rsp_valid` is high for exactly one cycle, three cycles after acceptance. `busy` is high in the two cycles in between.
- R10: Maintenance (`mnt_sel` 0 = segment map, 1 = page map; `mnt_write` 1 = write, 0 = read) is performed only when `mnt_ready`=1. Read data appears on `mnt_rdata` with `mnt_rvalid` one cycle later. While a translation is in flight `mnt_ready`=0 and maintenance is ignored. When idle, maintenance has priority: `busy` is high while `mnt_valid` is high.
- R11: A faulting response drives `rsp_pa`=0 and `rsp_nc`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_va | input | 32 | Virtual address |
| req_ctx | input | CTX_W | Current context |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| busy | output | 1 | New requests are not accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 28 | Physical address (0 on fault) |
| rsp_nc | output | 1 | Access must bypass cache |
| rsp_fault | output | 2 | 0 none, 1 hole, 2 invalid, 3 protection |
| mnt_valid | input | 1 | Maintenance access request |
| mnt_sel | input | 1 | 0 segment map, 1 page map |
| mnt_write | input | 1 | 1 write, 0 read |
| mnt_addr | input | MA_W | Map index |
| mnt_data | input | 32 | Write data (segment map uses low GRP_W bits) |
| mnt_ready | output | 1 | Maintenance is taken this cycle |
| mnt_rvalid | output | 1 | Read data valid |
| mnt_rdata | output | 32 | Read data, zero-extended for segment map |

## Verification
A wrong stored page-group number shows up three cycles after acceptance, as a response carrying a foreign frame number or an unexpected invalid fault. A corrupted status write-back is invisible in the response itself. It only appears when software reads the entry back through the maintenance port, one cycle after the read is issued. Wrong fault priority or a missed hole check shows as the wrong code on the single response pulse. A write-back on a faulting access shows as used or modified bits that appear on readback.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int VPG_W    = 6;
    localparam int PFN_W    = 16;
    localparam int PA_W     = PFN_W + OFF_W;
    localparam int SEG_LSB  = OFF_W + VPG_W;
    localparam int ENT_W    = 32;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_HOLE    = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PROT    = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PAGE  = 2'd1,
        ST_CHECK = 2'd2
    } xl_state_e;

    typedef struct packed {
        logic             valid;
        logic             wr_ok;
        logic             sup;
        logic             nc;
        logic [1:0]       space;
        logic             used;
        logic             modif;
        logic [7:0]       spare;
        logic [PFN_W-1:0] pfn;
    } pte_t;

    function automatic logic is_hole(input logic [2:0] top);
        return !((top == 3'b000) || (top == 3'b111));
    endfunction

endpackage

// File: rtl/spm_ram.sv
module spm_ram #(
    parameter int AW = 11,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/spm_check.sv
module spm_check
    import spm_pkg::*;
(
    input  pte_t   entry,
    input  logic   hole,
    input  logic   wr,
    input  logic   user,
    output fault_e fault,
    output pte_t   marked
);
    logic deny_wr;
    logic deny_user;

    always_comb begin
        deny_wr   = wr && !entry.wr_ok;
        deny_user = user && entry.sup;
        if (hole) begin
            fault = FLT_HOLE;
        end else if (!entry.valid) begin
            fault = FLT_INVALID;
        end else if (deny_wr || deny_user) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
    end

    always_comb begin
        marked      = entry;
        marked.used = 1'b1;
        if (wr) begin
            marked.modif = 1'b1;
        end
    end
endmodule

// File: rtl/spm_xlate.sv
module spm_xlate
    import spm_pkg::*;
#(
    parameter int CTX_W    = 3,
    parameter int SEG_BITS = 8,
    parameter int GRP_W    = 5,
    localparam int SEG_IDX_W = CTX_W + SEG_BITS,
    localparam int PG_IDX_W  = GRP_W + VPG_W,
    localparam int MA_W      = (SEG_IDX_W > PG_IDX_W) ? SEG_IDX_W : PG_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic [CTX_W-1:0] req_ctx,
    input  logic             req_write,
    input  logic             req_user,
    output logic             busy,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_nc,
    output logic [1:0]       rsp_fault,
    input  logic             mnt_valid,
    input  logic             mnt_sel,
    input  logic             mnt_write,
    input  logic [MA_W-1:0]  mnt_addr,
    input  logic [ENT_W-1:0] mnt_data,
    output logic             mnt_ready,
    output logic             mnt_rvalid,
    output logic [ENT_W-1:0] mnt_rdata
);
    xl_state_e state_q;

    logic [VA_W-1:0]     va_q;
    logic                wr_q;
    logic                user_q;
    logic                hole_q;
    logic [PG_IDX_W-1:0] pg_idx_q;

    logic                mnt_go;
    logic                accept;
    logic                wb_we;

    logic                seg_en, seg_we;
    logic [SEG_IDX_W-1:0] seg_addr;
    logic [GRP_W-1:0]    seg_rdata;

    logic                pg_en, pg_we;
    logic [PG_IDX_W-1:0] pg_addr;
    logic [ENT_W-1:0]    pg_wdata;
    logic [ENT_W-1:0]    pg_rdata;
    logic [PG_IDX_W-1:0] pg_lookup_idx;

    pte_t                cur_pte;
    pte_t                new_pte;
    fault_e              cur_fault;

    logic                rsp_valid_q;
    logic [PA_W-1:0]     rsp_pa_q;
    logic                rsp_nc_q;
    fault_e              rsp_fault_q;
    logic                mnt_rvalid_q;
    logic                mnt_rsel_q;

    // Handshake decisions
    assign mnt_ready = (state_q == ST_IDLE);
    assign mnt_go    = mnt_valid && mnt_ready;
    assign busy      = !mnt_ready || mnt_valid;
    assign accept    = req_valid && !busy;

    // Segment map port: maintenance or lookup at acceptance
    assign seg_en   = (mnt_go && !mnt_sel) || accept;
    assign seg_we   = mnt_go && mnt_write && !mnt_sel;
    assign seg_addr = mnt_go ? mnt_addr[SEG_IDX_W-1:0]
                             : {req_ctx, req_va[SEG_LSB +: SEG_BITS]};

    spm_ram #(
        .AW (SEG_IDX_W),
        .DW (GRP_W)
    ) u_segmap (
        .clk   (clk),
        .en    (seg_en),
        .we    (seg_we),
        .addr  (seg_addr),
        .wdata (mnt_data[GRP_W-1:0]),
        .rdata (seg_rdata)
    );

    // Page map port: maintenance, lookup, status write-back
    assign pg_lookup_idx = {seg_rdata, va_q[OFF_W +: VPG_W]};
    assign wb_we         = (state_q == ST_CHECK) && (cur_fault == FLT_NONE);

    always_comb begin
        pg_en    = 1'b0;
        pg_we    = 1'b0;
        pg_addr  = pg_idx_q;
        pg_wdata = new_pte;
        if (mnt_go) begin
            pg_en    = mnt_sel;
            pg_we    = mnt_sel && mnt_write;
            pg_addr  = mnt_addr[PG_IDX_W-1:0];
            pg_wdata = mnt_data;
        end else if (state_q == ST_PAGE) begin
            pg_en   = 1'b1;
            pg_addr = pg_lookup_idx;
        end else if (wb_we) begin
            pg_en = 1'b1;
            pg_we = 1'b1;
        end
    end

    spm_ram #(
        .AW (PG_IDX_W),
        .DW (ENT_W)
    ) u_pagemap (
        .clk   (clk),
        .en    (pg_en),
        .we    (pg_we),
        .addr  (pg_addr),
        .wdata (pg_wdata),
        .rdata (pg_rdata)
    );

    assign cur_pte = pte_t'(pg_rdata);

    spm_check u_check (
        .entry  (cur_pte),
        .hole   (hole_q),
        .wr     (wr_q),
        .user   (user_q),
        .fault  (cur_fault),
        .marked (new_pte)
    );

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            va_q     <= '0;
            wr_q     <= 1'b0;
            user_q   <= 1'b0;
            hole_q   <= 1'b0;
            pg_idx_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_PAGE;
                        va_q    <= req_va;
                        wr_q    <= req_write;
                        user_q  <= req_user;
                        hole_q  <= is_hole(req_va[VA_W-1 -: 3]);
                    end
                end
                ST_PAGE: begin
                    state_q  <= ST_CHECK;
                    pg_idx_q <= pg_lookup_idx;
                end
                ST_CHECK: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Response and maintenance read registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q  <= 1'b0;
            rsp_pa_q     <= '0;
            rsp_nc_q     <= 1'b0;
            rsp_fault_q  <= FLT_NONE;
            mnt_rvalid_q <= 1'b0;
            mnt_rsel_q   <= 1'b0;
        end else begin
            rsp_valid_q  <= (state_q == ST_CHECK);
            mnt_rvalid_q <= mnt_go && !mnt_write;
            if (mnt_go) begin
                mnt_rsel_q <= mnt_sel;
            end
            if (state_q == ST_CHECK) begin
                rsp_fault_q <= cur_fault;
                if (cur_fault == FLT_NONE) begin
                    rsp_pa_q <= {cur_pte.pfn, va_q[OFF_W-1:0]};
                    rsp_nc_q <= cur_pte.nc;
                end else begin
                    rsp_pa_q <= '0;
                    rsp_nc_q <= 1'b0;
                end
            end
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_pa     = rsp_pa_q;
    assign rsp_nc     = rsp_nc_q;
    assign rsp_fault  = rsp_fault_q;
    assign mnt_rvalid = mnt_rvalid_q;
    assign mnt_rdata  = mnt_rsel_q ? pg_rdata
                                   : {{(ENT_W-GRP_W){1'b0}}, seg_rdata};

    // Checks
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        accept |-> ##3 rsp_valid);  // R9

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);  // R9

    AST_HOLE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (accept && is_hole(req_va[VA_W-1 -: 3])) |-> ##3 (rsp_fault == FLT_HOLE));  // R2

    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_fault != FLT_NONE)) |-> ((rsp_pa == '0) && !rsp_nc));  // R11

    AST_WB_ONLY_OK: assert property (@(posedge clk) disable iff (rst)
        (pg_we && !mnt_go) |=> (rsp_valid && (rsp_fault == FLT_NONE)));  // R8

    AST_MNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        mnt_rvalid |-> ($past(state_q) == ST_IDLE));  // R10
endmodule

// File: tb/sim_spm_xlate.sv
module sim_spm_xlate;
    import spm_pkg::*;

    localparam int CTX_W = 3;
    localparam int MA_W  = 11;

    localparam logic [31:0] ENT_A = 32'hC000ABCD; // valid, write ok
    localparam logic [31:0] ENT_B = 32'hB0001234; // valid, supervisor, nc
    localparam logic [31:0] ENT_C = 32'hF000FFFF; // valid, wr, sup, nc
    localparam logic [31:0] ENT_D = 32'h20005555; // invalid, sup, no write
    localparam logic [31:0] ENT_E = 32'h80000042; // valid, read only
    localparam logic [31:0] BIT_U = 32'h02000000;
    localparam logic [31:0] BIT_M = 32'h01000000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst;
    logic             req_valid;
    logic [31:0]      req_va;
    logic [CTX_W-1:0] req_ctx;
    logic             req_write;
    logic             req_user;
    logic             busy;
    logic             rsp_valid;
    logic [27:0]      rsp_pa;
    logic             rsp_nc;
    logic [1:0]       rsp_fault;
    logic             mnt_valid;
    logic             mnt_sel;
    logic             mnt_write;
    logic [MA_W-1:0]  mnt_addr;
    logic [31:0]      mnt_data;
    logic             mnt_ready;
    logic             mnt_rvalid;
    logic [31:0]      mnt_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    spm_xlate u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_va(req_va), .req_ctx(req_ctx),
        .req_write(req_write), .req_user(req_user), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_nc(rsp_nc),
        .rsp_fault(rsp_fault),
        .mnt_valid(mnt_valid), .mnt_sel(mnt_sel), .mnt_write(mnt_write),
        .mnt_addr(mnt_addr), .mnt_data(mnt_data), .mnt_ready(mnt_ready),
        .mnt_rvalid(mnt_rvalid), .mnt_rdata(mnt_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkva(input logic [2:0] top, input logic [7:0] seg,
                                         input logic [5:0] pg, input logic [11:0] off);
        return {top, 3'b000, seg, pg, off};
    endfunction

    function automatic logic [MA_W-1:0] sidx(input logic [2:0] ctx, input logic [7:0] seg);
        return {ctx, seg};
    endfunction

    function automatic logic [MA_W-1:0] pidx(input logic [4:0] grp, input logic [5:0] pg);
        return {grp, pg};
    endfunction

    task automatic mnt_wr(input logic sel, input logic [MA_W-1:0] addr, input logic [31:0] data);
        @(negedge clk);
        mnt_valid = 1'b1; mnt_sel = sel; mnt_write = 1'b1;
        mnt_addr = addr; mnt_data = data;
        @(negedge clk);
        mnt_valid = 1'b0; mnt_write = 1'b0;
    endtask

    task automatic mnt_rd_chk(input string tag, input logic sel, input logic [MA_W-1:0] addr,
                              input logic [31:0] exp);
        @(negedge clk);
        mnt_valid = 1'b1; mnt_sel = sel; mnt_write = 1'b0; mnt_addr = addr;
        @(negedge clk);
        mnt_valid = 1'b0;
        chk({tag, " rvalid"}, {31'b0, mnt_rvalid}, 32'd1);
        chk({tag, " rdata"}, mnt_rdata, exp);
    endtask

    task automatic translate(input string tag, input logic [31:0] va, input logic [2:0] ctx,
                             input logic wr, input logic user, input logic [1:0] exp_flt,
                             input logic [27:0] exp_pa, input logic exp_nc);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_ctx = ctx; req_write = wr; req_user = user;
        #1;
        chk({tag, " R9 busy before accept"}, {31'b0, busy}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R9 busy n1"}, {31'b0, busy}, 32'd1);
        chk({tag, " R9 no early rsp n1"}, {31'b0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk({tag, " R9 busy n2"}, {31'b0, busy}, 32'd1);
        chk({tag, " R9 no early rsp n2"}, {31'b0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk({tag, " R9 rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
        chk({tag, " fault"}, {30'b0, rsp_fault}, {30'b0, exp_flt});
        chk({tag, " pa"}, {4'b0, rsp_pa}, {4'b0, exp_pa});
        chk({tag, " nc"}, {31'b0, rsp_nc}, {31'b0, exp_nc});
        @(negedge clk);
        chk({tag, " R9 pulse ends"}, {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req_valid = 1'b0; req_va = '0; req_ctx = '0; req_write = 1'b0; req_user = 1'b0;
        mnt_valid = 1'b0; mnt_sel = 1'b0; mnt_write = 1'b0; mnt_addr = '0; mnt_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R1 mnt_rvalid", {31'b0, mnt_rvalid}, 32'd0);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 mnt_ready", {31'b0, mnt_ready}, 32'd1);
    endtask

    task automatic t_load();
        mnt_wr(1'b0, sidx(3'd1, 8'h05), 32'd3);
        mnt_wr(1'b0, sidx(3'd6, 8'hFF), 32'h1F);
        mnt_wr(1'b0, sidx(3'd0, 8'h00), 32'd2);
        mnt_wr(1'b0, sidx(3'd0, 8'h05), 32'd4);
        mnt_wr(1'b1, pidx(5'd3, 6'h10), ENT_A);
        mnt_wr(1'b1, pidx(5'd3, 6'h11), ENT_B);
        mnt_wr(1'b1, pidx(5'h1F, 6'h3F), ENT_D);
        mnt_wr(1'b1, pidx(5'd2, 6'h00), ENT_C);
        mnt_wr(1'b1, pidx(5'd4, 6'h10), ENT_E);
        mnt_rd_chk("R10 seg readback", 1'b0, sidx(3'd6, 8'hFF), 32'h1F);
        mnt_rd_chk("R10 page readback", 1'b1, pidx(5'd3, 6'h11), ENT_B);
    endtask

    task automatic t_read_ok();
        translate("R4 user read A", mkva(3'b000, 8'h05, 6'h10, 12'h5A5), 3'd1, 1'b0, 1'b1,
                  2'd0, 28'hABCD5A5, 1'b0);
        mnt_rd_chk("R8 used set on read", 1'b1, pidx(5'd3, 6'h10), ENT_A | BIT_U);
    endtask

    task automatic t_hole();
        translate("R2 hole write on A", mkva(3'b010, 8'h05, 6'h10, 12'h001), 3'd1, 1'b1, 1'b0,
                  2'd1, 28'h0, 1'b0);
        mnt_rd_chk("R2 hole leaves entry", 1'b1, pidx(5'd3, 6'h10), ENT_A | BIT_U);
        translate("R7 hole beats invalid", mkva(3'b100, 8'hFF, 6'h3F, 12'h0), 3'd6, 1'b1, 1'b1,
                  2'd1, 28'h0, 1'b0);
    endtask

    task automatic t_write_ok();
        translate("R8 sup write A", mkva(3'b000, 8'h05, 6'h10, 12'hFFF), 3'd1, 1'b1, 1'b0,
                  2'd0, 28'hABCDFFF, 1'b0);
        mnt_rd_chk("R8 used and modified", 1'b1, pidx(5'd3, 6'h10), ENT_A | BIT_U | BIT_M);
    endtask

    task automatic t_prot();
        translate("R6 write to read-only B", mkva(3'b000, 8'h05, 6'h11, 12'h010), 3'd1, 1'b1, 1'b0,
                  2'd3, 28'h0, 1'b0);
        translate("R6 user on supervisor B", mkva(3'b000, 8'h05, 6'h11, 12'h010), 3'd1, 1'b0, 1'b1,
                  2'd3, 28'h0, 1'b0);
        mnt_rd_chk("R8 fault leaves B", 1'b1, pidx(5'd3, 6'h11), ENT_B);
        translate("R4 sup read B nc", mkva(3'b000, 8'h05, 6'h11, 12'h777), 3'd1, 1'b0, 1'b0,
                  2'd0, 28'h1234777, 1'b1);
        mnt_rd_chk("R8 B used", 1'b1, pidx(5'd3, 6'h11), ENT_B | BIT_U);
    endtask

    task automatic t_invalid();
        translate("R5 R7 invalid beats prot", mkva(3'b000, 8'hFF, 6'h3F, 12'h0), 3'd6, 1'b1, 1'b1,
                  2'd2, 28'h0, 1'b0);
        mnt_rd_chk("R5 invalid entry unchanged", 1'b1, pidx(5'h1F, 6'h3F), ENT_D);
    endtask

    task automatic t_index();
        translate("R3 upper half top 111", mkva(3'b111, 8'h00, 6'h00, 12'hFFF), 3'd0, 1'b1, 1'b0,
                  2'd0, 28'hFFFFFFF, 1'b1);
        translate("R3 context selects group", mkva(3'b000, 8'h05, 6'h10, 12'h123), 3'd0, 1'b0, 1'b1,
                  2'd0, 28'h0042123, 1'b0);
    endtask

    task automatic t_mnt_priority();
        @(negedge clk);
        mnt_valid = 1'b1; mnt_sel = 1'b1; mnt_write = 1'b1;
        mnt_addr = pidx(5'd4, 6'h10); mnt_data = 32'h80000077;
        req_valid = 1'b1; req_va = mkva(3'b000, 8'h05, 6'h10, 12'h321); req_ctx = 3'd0;
        req_write = 1'b0; req_user = 1'b1;
        #1;
        chk("R10 busy while maintenance pending", {31'b0, busy}, 32'd1);
        @(negedge clk);
        mnt_valid = 1'b0; mnt_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 request waits", {31'b0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk("R10 no rsp yet", {31'b0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk("R10 delayed rsp", {31'b0, rsp_valid}, 32'd1);
        chk("R10 rsp uses new entry", {4'b0, rsp_pa}, 32'h0077321);
        mnt_rd_chk("R10 maintenance write landed", 1'b1, pidx(5'd4, 6'h10), 32'h80000077 | BIT_U);
    endtask

    task automatic t_mnt_in_flight();
        @(negedge clk);
        req_valid = 1'b1; req_va = mkva(3'b000, 8'h05, 6'h10, 12'h0AA); req_ctx = 3'd1;
        req_write = 1'b0; req_user = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 mnt_ready low in flight", {31'b0, mnt_ready}, 32'd0);
        mnt_valid = 1'b1; mnt_sel = 1'b1; mnt_write = 1'b0; mnt_addr = pidx(5'd3, 6'h10);
        @(negedge clk);
        chk("R10 read ignored in flight", {31'b0, mnt_rvalid}, 32'd0);
        mnt_sel = 1'b0; mnt_write = 1'b1; mnt_addr = sidx(3'd1, 8'h05); mnt_data = 32'd7;
        @(negedge clk);
        mnt_valid = 1'b0; mnt_write = 1'b0;
        chk("R10 flight rsp", {4'b0, rsp_pa}, 32'hABCD0AA);
        translate("R10 seg write ignored", mkva(3'b000, 8'h05, 6'h10, 12'h0BB), 3'd1, 1'b0, 1'b0,
                  2'd0, 28'hABCD0BB, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load();
        t_read_ok();
        t_hole();
        t_write_ok();
        t_prot();
        t_invalid();
        t_index();
        t_mnt_priority();
        t_mnt_in_flight();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule